// File: doc/BRIEF.md
# Cascadable Priority Encoder

The block turns a set of active-low request lines into the binary index of the most urgent asserted request. Its building element is an eight-lane stage. All of the stage's signals are active low: eight requests, an enable input, a three-bit index, a group-active flag and a pass-down enable. The pass-down enable feeds the next, less urgent stage. A stage reports a request only while it is enabled. It passes the enable on only when it is enabled and none of its own requests is asserted.

The top level chains two stages into a sixteen-lane encoder with active-high outputs. The upper stage holds lanes 15..8 and the lower stage holds lanes 7..0. The upper stage's pass-down enable enables the lower stage. The most significant code bit is the upper stage's group flag inverted. Each lower code bit is the NAND of the two stages' matching index bits. Because a stage that is idle or disabled drives its index bits high, only the active stage shapes the result.

The block is purely combinational. Its outputs settle in the same cycle as its inputs. It holds no state.

Top module: `prio_enc16`

## Requirements
- R1: When enabled (`en_n` = 0) with at least one request low, `code` equals the highest lane number i for which `req_n[i]` = 0. Lane 15 is the most urgent and lane 0 the least.
- R2: `valid` is 1 exactly when `en_n` = 0 and at least one bit of `req_n` is 0.
- R3: `eo_n` is 0 exactly when `en_n` = 0 and every bit of `req_n` is 1.
- R4: While `en_n` = 1, the outputs are `code` = 0, `valid` = 0 and `eo_n` = 1, whatever the requests are.
- R5: An asserted request in lanes 15..8 sets `code[3]` = 1. Any asserted requests in lanes 7..0 then have no effect on `code`.
- R6: When only lanes 7..0 have asserted requests, `code[3]` = 0 and `code[2:0]` is the highest asserted lane among them.
- R7: When enabled with no request asserted, `code` reads 0000.
- R8: Inside each stage, the group flag and the pass-down enable are never low at the same time. A low group flag means the lane given by the inverted index is asserted and every lane above it in that stage is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Active-low requests; bit 15 is the most urgent |
| en_n | input | 1 | Active-low enable of the whole chain |
| code | output | 4 | Active-high index of the winning request |
| valid | output | 1 | Active-high flag: some request won |
| eo_n | output | 1 | Active-low enable for a further, less urgent encoder |

## Verification
The block holds no state, so any fault in a stage shows up at the ports in the same cycle as the stimulus that exposes it. An index bit that a stage drives low while idle corrupts `code` for every request in the other half. A pass-down enable that asserts while the upper stage is active makes a lower-lane request overwrite the upper index. Single-lane sweeps combined with patterns that assert lanes in both halves expose both faults at once. A wrong disable path shows as a nonzero `code` or a low `eo_n` while `en_n` is high.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned MAX_LANES = 16;
  localparam int unsigned MAX_IW    = $clog2(MAX_LANES);

  typedef struct packed {
    logic              hit;
    logic [MAX_IW-1:0] idx;
  } pick_t;

  // Highest set bit of an active-high request vector (upper lanes win).
  function automatic pick_t pick_top(input logic [MAX_LANES-1:0] act);
    pick_t r;
    r = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (act[i]) begin
        r.hit = 1'b1;
        r.idx = MAX_IW'(i);
      end
    end
    return r;
  endfunction

  function automatic logic nand2(input logic a, input logic b);
    return ~(a & b);
  endfunction
endpackage

// File: rtl/prio_stage.sv
module prio_stage
  import prio_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] req_n,
  input  logic             ei_n,
  output logic [IW-1:0]    a_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic [MAX_LANES-1:0] act_ext;
  pick_t                pick;
  logic                 stage_on;
  logic                 req_seen;
  logic [IW:0]          sel;

  always_comb begin
    act_ext            = '0;
    act_ext[LANES-1:0] = ~req_n;
    pick               = pick_top(act_ext);
  end

  assign stage_on = ~ei_n;
  assign req_seen = pick.hit;

  always_comb begin
    a_n  = '1;
    gs_n = 1'b1;
    eo_n = 1'b1;
    if (stage_on) begin
      if (req_seen) begin
        a_n  = ~pick.idx[IW-1:0];
        gs_n = 1'b0;
      end else begin
        eo_n = 1'b0;
      end
    end
  end

  assign sel = {1'b0, ~a_n};

  // Checks next to the stage logic.
  always_comb begin
    p_excl_r8: assert (gs_n | eo_n)
      else $error("stage group flag and pass-down both low");
    p_off_r4: assert (!ei_n || (gs_n && eo_n && (&a_n)))
      else $error("disabled stage drives an active output");
    p_pass_r3: assert (eo_n || (&req_n))
      else $error("pass-down asserted with a pending request");
    p_win_r8: assert (gs_n || (req_n[sel[IW-1:0]] == 1'b0))
      else $error("reported lane is not asserted");
    p_above_r1: assert (gs_n || (&(req_n | ~({LANES{1'b1}} << (sel + 1'b1)))))
      else $error("a more urgent lane is asserted");
  end

  initial begin
    p_lanes_r1: assert (LANES <= MAX_LANES && LANES >= 2)
      else $error("stage width out of range");
  end
endmodule

// File: rtl/prio_merge.sv
module prio_merge
  import prio_pkg::*;
#(
  parameter int unsigned IW = 3
) (
  input  logic [IW-1:0] up_a_n,
  input  logic          up_gs_n,
  input  logic [IW-1:0] lo_a_n,
  input  logic          lo_gs_n,
  output logic [IW:0]   code,
  output logic          valid
);
  genvar g;
  generate
    for (g = 0; g < IW; g++) begin : g_bit
      assign code[g] = nand2(up_a_n[g], lo_a_n[g]);
    end
  endgenerate

  assign code[IW] = ~up_gs_n;
  assign valid    = nand2(up_gs_n, lo_gs_n);

  // The two stages are never active together.
  always_comb begin
    p_one_grp_r5: assert (up_gs_n | lo_gs_n)
      else $error("both halves claim the request");
    p_idle_code_r7: assert (valid || (code == '0))
      else $error("nonzero code with no winner");
  end
endmodule

// File: rtl/prio_enc16.sv
module prio_enc16
  import prio_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned IW    = $clog2(LANES),
  localparam int unsigned CW    = IW + 1,
  localparam int unsigned TOTAL = 2 * LANES
) (
  input  logic [TOTAL-1:0] req_n,
  input  logic             en_n,
  output logic [CW-1:0]    code,
  output logic             valid,
  output logic             eo_n
);
  logic [IW-1:0] up_a_n, lo_a_n;
  logic          up_gs_n, lo_gs_n;
  logic          chain_en_n;

  prio_stage #(.LANES(LANES)) u_upper (
    .req_n (req_n[TOTAL-1:LANES]),
    .ei_n  (en_n),
    .a_n   (up_a_n),
    .gs_n  (up_gs_n),
    .eo_n  (chain_en_n)
  );

  prio_stage #(.LANES(LANES)) u_lower (
    .req_n (req_n[LANES-1:0]),
    .ei_n  (chain_en_n),
    .a_n   (lo_a_n),
    .gs_n  (lo_gs_n),
    .eo_n  (eo_n)
  );

  prio_merge #(.IW(IW)) u_merge (
    .up_a_n  (up_a_n),
    .up_gs_n (up_gs_n),
    .lo_a_n  (lo_a_n),
    .lo_gs_n (lo_gs_n),
    .code    (code),
    .valid   (valid)
  );

  always_comb begin
    p_valid_r2: assert (valid == (!en_n && !(&req_n)))
      else $error("valid disagrees with the requests");
    p_off_r4: assert (!en_n || (code == '0 && !valid && eo_n))
      else $error("disabled chain drives outputs");
    p_upper_r5: assert (en_n || (&req_n[TOTAL-1:LANES]) || code[IW])
      else $error("upper request lost to lower half");
    p_chain_r3: assert (eo_n || (!en_n && (&req_n)))
      else $error("chain enable out asserted wrongly");
  end
endmodule

// File: tb/prio_enc16_bench.sv
module prio_enc16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_n = '1;
  logic        en_n = 1'b1;
  logic [3:0]  code;
  logic        valid;
  logic        eo_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] code;
    logic       valid;
    logic       eo_n;
    string      tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  prio_enc16 u_prio_enc16 (
    .req_n (req_n),
    .en_n  (en_n),
    .code  (code),
    .valid (valid),
    .eo_n  (eo_n)
  );

  // Reference: scan from the most urgent lane down.
  function automatic item_t model(input logic [15:0] r, input logic e, input string tag);
    item_t it;
    it.code = 4'd0; it.valid = 1'b0; it.eo_n = 1'b1; it.tag = tag;
    if (!e) begin
      it.eo_n = 1'b0;
      for (int i = 15; i >= 0; i--) begin
        if (!r[i]) begin
          it.code = 4'(i); it.valid = 1'b1; it.eo_n = 1'b1;
          break;
        end
      end
    end
    return it;
  endfunction

  task automatic drive(input logic [15:0] r, input logic e, input string tag);
    @(posedge clk);
    req_n <= r;
    en_n  <= e;
    sb.push_back(model(r, e, tag));
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      cmp({e.tag, " code (R1)"}, int'(code), int'(e.code));
      cmp({e.tag, " valid (R2)"}, int'(valid), int'(e.valid));
      cmp({e.tag, " eo_n (R3)"}, int'(eo_n), int'(e.eo_n));
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst <= 1'b0;
    // Reset state: chain disabled, no requests (R4)
    drive(16'hFFFF, 1'b1, "R4 reset idle");
    // Disabled with requests pending (R4)
    drive(16'h0000, 1'b1, "R4 disabled all");
    drive(16'h7FFE, 1'b1, "R4 disabled mixed");
    // Enabled, nothing pending (R7, R3)
    drive(16'hFFFF, 1'b0, "R7 no request");
    // Every lane alone (R1, R5, R6)
    for (int i = 0; i < 16; i++)
      drive(~(16'h1 << i), 1'b0, (i >= 8) ? "R5 single upper" : "R6 single lower");
    // Both halves active: upper wins (R5)
    drive(16'h7FFE, 1'b0, "R5 lanes 15 and 0");
    drive(16'hFE00, 1'b0, "R5 lane 8 vs low byte");
    drive(16'h0000, 1'b0, "R1 all asserted");
    // Lower only, several lanes (R6)
    drive(16'hFF5A, 1'b0, "R6 lower multi");
    drive(16'hFFFC, 1'b0, "R6 lanes 1 and 0");
    // Random patterns, enabled and not (R1 R2 R3 R8)
    for (int k = 0; k < 300; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (k % 3 == 0) r = r | 16'hFF00;
      drive(r, (k % 11 == 0), "R8 random");
    end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    cmp("R1 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule